// File: doc/BRIEF.md
# Parallel RGB Panel Output Formatter

This block takes 24-bit RGB pixels, together with horizontal sync, vertical sync and data-enable, from a video timing source in the pixel clock domain. It drives a parallel RGB panel. Each pixel first passes a programmable channel swap. The result is then laid onto 24 data lines in one of several 16-, 18- or 24-bit arrangements, with zeros in the unused positions. Each control line has its own polarity setting, its own choice of launch edge and its own disable. The pixel clock sent to the panel can also be inverted.

Software reaches the block through a small register bus. Offset zero holds a single control word. A read at any other offset returns a fixed identification constant. Everything is registered once on the rising pixel-clock edge, so data and control lines stay aligned. Setting the enable bit after it was clear empties that pipeline stage, so stale pixels never reach the panel.

Top module: `rgb_pin_formatter`

## Requirements
- R1: After reset the control word reads 0. The data lines are 0. The horizontal sync, vertical sync and data-enable pins are low.
- R2: Control bits 15:14 choose the channel swap, as (red, green, blue) slots filled from the input channels. Code 0 gives (R,G,B), code 1 gives (B,G,R), code 2 gives (G,R,B) and code 3 gives (B,R,G). The input pixel is red 23:16, green 15:8, blue 7:0. Packing works on the swapped channels.
- R3: Control bits 13:11 choose the packing. Reduced widths keep the top bits of each channel.
  - Code 1: red[7:3] at 15:11, green[7:2] at 10:5, blue[7:3] at 4:0.
  - Code 2: red[7:3] at 20:16, green[7:2] at 13:8, blue[7:3] at 4:0.
  - Code 3: red[7:3] at 21:17, green[7:2] at 13:8, blue[7:3] at 5:1.
  - Code 4: red[7:2] at 17:12, green[7:2] at 11:6, blue[7:2] at 5:0.
  - Code 5: red[7:2] at 21:16, green[7:2] at 13:8, blue[7:2] at 5:0.
  - Code 6: all 24 bits unchanged.
  - All other data lines are zero.
- R4: Packing codes 0 and 7 drive every data line to zero.
- R5: Control bits 10, 9, 8 and 7 invert the pixel clock, horizontal sync, vertical sync and data-enable pins respectively.
- R6: Control bits 6, 5 and 4 move the launch of horizontal sync, vertical sync and data-enable to the falling pixel-clock edge that follows the capturing rising edge. This delays the pin by half a cycle.
- R7: Control bits 3, 2 and 1 disable horizontal sync, vertical sync and data-enable. A disabled pin sits at its inactive level, which is its polarity bit.
- R8: Control bit 0 enables the block. While it is 0, every data line is 0 and every control pin sits at its inactive level. A write that sets it from 0 clears the pipeline stage, so the first cycle after the write shows zero data and inactive controls.
- R9: A read at offset 0 returns control bits 16:0, zero-extended. A read at any other offset returns 0x00647069. A write at a nonzero offset changes nothing.
- R10: With control bit 16 set, the data-enable pin carries the data-enable input. With it clear, the pin carries horizontal sync XOR vertical sync.
- R11: Data and rising-launched control pins appear exactly one rising pixel-clock edge after their inputs, aligned with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | BUS_W | Register write data |
| reg_rdata | output | BUS_W | Register read data, combinational from address |
| pix_in | input | 24 | Input pixel, red 23:16, green 15:8, blue 7:0 |
| hs_in | input | 1 | Horizontal sync input, active high |
| vs_in | input | 1 | Vertical sync input, active high |
| de_in | input | 1 | Data-enable input, active high |
| pix_out | output | 24 | Packed panel data lines |
| hs_out | output | 1 | Horizontal sync pin |
| vs_out | output | 1 | Vertical sync pin |
| de_out | output | 1 | Data-enable or composite sync pin |
| pclk_out | output | 1 | Pixel clock to panel, optionally inverted |

## Verification
The only internal state is the control word, one data stage and, per control line, a rising-edge and a falling-edge stage. A corrupt control bit shows within one cycle on the data lines or on a control pin: a moved colour field, a wrong inactive level or a half-cycle shift. A missed pipeline clear shows up as one stale pixel on the first cycle after enabling. A wrong latency is seen by sampling just before and just after the capturing edge. A falling-edge stage is seen by sampling both halves of the cycle.

// File: rtl/rgb_fmt_pkg.sv
package rgb_fmt_pkg;

  localparam int CH_W  = 8;
  localparam int PIX_W = 3 * CH_W;
  localparam int LANES = 3;  // 2 = hsync, 1 = vsync, 0 = data-enable

  typedef enum logic [1:0] {
    ORD_RGB = 2'd0,
    ORD_BGR = 2'd1,
    ORD_GRB = 2'd2,
    ORD_BRG = 2'd3
  } order_e;

  typedef enum logic [2:0] {
    PK_ZERO   = 3'd0,
    PK_16_LO  = 3'd1,
    PK_16_MID = 3'd2,
    PK_16_HI  = 3'd3,
    PK_18_LO  = 3'd4,
    PK_18_GAP = 3'd5,
    PK_24     = 3'd6,
    PK_RSVD   = 3'd7
  } pack_e;

  typedef struct packed {
    logic                de_is_enable;  // bit 16
    order_e              order;         // bits 15:14
    pack_e               pack;          // bits 13:11
    logic                pclk_inv;      // bit 10
    logic [LANES-1:0]    inv;           // bits 9:7
    logic [LANES-1:0]    fall;          // bits 6:4
    logic [LANES-1:0]    dis;           // bits 3:1
    logic                en;            // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/fmt_ctrl_regs.sv
module fmt_ctrl_regs
  import rgb_fmt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          BUS_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output ctrl_t             ctrl,
  output logic              flush
);

  localparam int PAD_W = BUS_W - CTRL_W;

  ctrl_t ctrl_q, ctrl_d;
  logic  hit;

  assign hit = wr && (addr == '0);

  always_comb begin
    ctrl_d = ctrl_q;
    if (hit) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // Enable rising through a write: clear the pipeline on the same edge
  assign flush = hit && wdata[0] && !ctrl_q.en;
  assign ctrl  = ctrl_q;
  assign rdata = (addr == '0) ? {{PAD_W{1'b0}}, ctrl_q} : BUS_W'(ID_VALUE);

endmodule

// File: rtl/fmt_pixel_path.sv
module fmt_pixel_path
  import rgb_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  order_e           order,
  input  pack_e            pack,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] pix_q
);

  logic [CH_W-1:0]  in_r, in_g, in_b;
  logic [CH_W-1:0]  sw_r, sw_g, sw_b;
  logic [PIX_W-1:0] packed_pix, pix_d;

  assign in_r = pix_in[3*CH_W-1:2*CH_W];
  assign in_g = pix_in[2*CH_W-1:CH_W];
  assign in_b = pix_in[CH_W-1:0];

  always_comb begin
    case (order)
      ORD_BGR: begin sw_r = in_b; sw_g = in_g; sw_b = in_r; end
      ORD_GRB: begin sw_r = in_g; sw_g = in_r; sw_b = in_b; end
      ORD_BRG: begin sw_r = in_b; sw_g = in_r; sw_b = in_g; end
      default: begin sw_r = in_r; sw_g = in_g; sw_b = in_b; end
    endcase
  end

  always_comb begin
    case (pack)
      PK_16_LO:  packed_pix = {8'h00, sw_r[7:3], sw_g[7:2], sw_b[7:3]};
      PK_16_MID: packed_pix = {3'b0, sw_r[7:3], 2'b0, sw_g[7:2], 3'b0, sw_b[7:3]};
      PK_16_HI:  packed_pix = {2'b0, sw_r[7:3], 3'b0, sw_g[7:2], 2'b0, sw_b[7:3], 1'b0};
      PK_18_LO:  packed_pix = {6'b0, sw_r[7:2], sw_g[7:2], sw_b[7:2]};
      PK_18_GAP: packed_pix = {2'b0, sw_r[7:2], 2'b0, sw_g[7:2], 2'b0, sw_b[7:2]};
      PK_24:     packed_pix = {sw_r, sw_g, sw_b};
      default:   packed_pix = '0;
    endcase
  end

  assign pix_d = flush ? '0 : packed_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= pix_d;
  end

endmodule

// File: rtl/fmt_sync_lane.sv
module fmt_sync_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic raw_in,
  input  logic en,
  input  logic inv,
  input  logic fall,
  input  logic dis,
  output logic pin
);

  logic rise_q, rise_d, fall_q, sel, active;

  assign rise_d = flush ? 1'b0 : raw_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= rise_d;
  end

  // Half-cycle retime for falling-edge launch
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q;
  end

  assign sel    = fall ? fall_q : rise_q;
  assign active = en && !dis && sel;
  assign pin    = active ^ inv;

endmodule

// File: rtl/rgb_pin_formatter.sv
module rgb_pin_formatter
  import rgb_fmt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          BUS_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic [23:0]       pix_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              de_in,
  output logic [23:0]       pix_out,
  output logic              hs_out,
  output logic              vs_out,
  output logic              de_out,
  output logic              pclk_out
);

  logic [1:0]       rst_sync_q, rst_sync_d;
  logic             core_rst_n;
  ctrl_t            ctrl;
  logic             flush;
  logic [PIX_W-1:0] data_q;
  logic [LANES-1:0] raw, pin;
  logic             de_sel;

  // Asynchronous assert, synchronous release
  assign rst_sync_d = {rst_sync_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= rst_sync_d;
  end
  assign core_rst_n = rst_sync_q[1];

  fmt_ctrl_regs #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .ID_VALUE(ID_VALUE)
  ) u_regs (
    .clk(clk), .rst_n(core_rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl), .flush(flush)
  );

  fmt_pixel_path u_data (
    .clk(clk), .rst_n(core_rst_n), .flush(flush), .order(ctrl.order),
    .pack(ctrl.pack), .pix_in(pix_in), .pix_q(data_q)
  );

  assign de_sel = ctrl.de_is_enable ? de_in : (hs_in ^ vs_in);
  assign raw    = {hs_in, vs_in, de_sel};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fmt_sync_lane u_lane (
      .clk(clk), .rst_n(core_rst_n), .flush(flush), .raw_in(raw[i]),
      .en(ctrl.en), .inv(ctrl.inv[i]), .fall(ctrl.fall[i]),
      .dis(ctrl.dis[i]), .pin(pin[i])
    );
  end

  assign pix_out  = ctrl.en ? data_q : '0;
  assign hs_out   = pin[2];
  assign vs_out   = pin[1];
  assign de_out   = pin[0];
  assign pclk_out = clk ^ ctrl.pclk_inv;

endmodule

// File: rtl/rgb_pin_formatter_chk.sv
module rgb_pin_formatter_chk
  import rgb_fmt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          BUS_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input logic              clk,
  input logic              core_rst_n,
  input ctrl_t             ctrl,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BUS_W-1:0]  reg_rdata,
  input logic [23:0]       pix_in,
  input logic              hs_in,
  input logic              vs_in,
  input logic [23:0]       pix_out,
  input logic              hs_out,
  input logic              de_out
);

  a_r9_id_read: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_addr != '0) |-> (reg_rdata == BUS_W'(ID_VALUE)));

  a_r8_enable_clears: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(ctrl.en) |-> (pix_out == '0));

  a_r4_zero_pack: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($past(ctrl.pack) == PK_ZERO || $past(ctrl.pack) == PK_RSVD) |-> (pix_out == '0));

  a_r7_hs_disabled: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctrl.dis[2] |-> (hs_out == ctrl.inv[2]));

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ctrl.en && ctrl.pack == PK_24 && ctrl.order == ORD_RGB && $past(ctrl) == ctrl)
    |-> (pix_out == $past(pix_in)));

  a_r10_composite: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ctrl.en && !ctrl.de_is_enable && !ctrl.fall[0] && !ctrl.dis[0] &&
     !ctrl.inv[0] && $past(ctrl) == ctrl)
    |-> (de_out == $past(hs_in ^ vs_in)));

endmodule

bind rgb_pin_formatter rgb_pin_formatter_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk(clk), .core_rst_n(core_rst_n), .ctrl(ctrl), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in),
  .pix_out(pix_out), .hs_out(hs_out), .de_out(de_out)
);

// File: tb/rgb_pin_formatter_test.sv
module rgb_pin_formatter_test;

  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;
  localparam int NVEC   = 20;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [BUS_W-1:0]  reg_wdata;
  logic [BUS_W-1:0]  reg_rdata;
  logic [23:0]       pix_in, pix_out;
  logic              hs_in, vs_in, de_in;
  logic              hs_out, vs_out, de_out, pclk_out;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #2 clk = ~clk;  // 250 MHz

  rgb_pin_formatter #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_in(pix_in),
    .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in), .pix_out(pix_out),
    .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out), .pclk_out(pclk_out)
  );

  // {order[1:0], pack[2:0], pixel[23:0], expected[23:0]}
  localparam logic [52:0] VEC [NVEC] = '{
    {2'd0, 3'd6, 24'hFF0000, 24'hFF0000},
    {2'd0, 3'd1, 24'hFF0000, 24'h00F800},
    {2'd0, 3'd2, 24'hFF0000, 24'h1F0000},
    {2'd0, 3'd3, 24'hFF0000, 24'h3E0000},
    {2'd0, 3'd4, 24'hFF0000, 24'h03F000},
    {2'd0, 3'd5, 24'hFF0000, 24'h3F0000},
    {2'd0, 3'd1, 24'h00FF00, 24'h0007E0},
    {2'd0, 3'd2, 24'h00FF00, 24'h003F00},
    {2'd0, 3'd4, 24'h00FF00, 24'h000FC0},
    {2'd0, 3'd5, 24'h00FF00, 24'h003F00},
    {2'd0, 3'd3, 24'h0000FF, 24'h00003E},
    {2'd0, 3'd4, 24'h0000FF, 24'h00003F},
    {2'd0, 3'd1, 24'h800000, 24'h008000},
    {2'd0, 3'd1, 24'h070000, 24'h000000},
    {2'd0, 3'd0, 24'hFFFFFF, 24'h000000},
    {2'd0, 3'd7, 24'hFFFFFF, 24'h000000},
    {2'd1, 3'd6, 24'h112233, 24'h332211},
    {2'd2, 3'd6, 24'h112233, 24'h221133},
    {2'd3, 3'd6, 24'h112233, 24'h331122},
    {2'd1, 3'd2, 24'h0000FF, 24'h1F0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [31:0] word);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = '0; reg_wdata = word;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Drive at current (falling) edge, sample 1 ns after next rising edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] cword(input logic [1:0] ord, input logic [2:0] pk);
    return (32'd1 << 16) | (32'(ord) << 14) | (32'(pk) << 11) | 32'd1;
  endfunction

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pix_in = '0; hs_in = 1'b0; vs_in = 1'b0; de_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 ctrl", reg_rdata, 32'h0);
    check("R1 data", {8'h0, pix_out}, 32'h0);
    check("R1 sync", {29'h0, hs_out, vs_out, de_out}, 32'h0);

    // R9 reads and nonzero-offset writes
    reg_addr = 4'h4; #1;
    check("R9 id 4", reg_rdata, 32'h0064_7069);
    reg_addr = 4'hC; #1;
    check("R9 id C", reg_rdata, 32'h0064_7069);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; #1;
    check("R9 ignored write", reg_rdata, 32'h0);
    set_ctrl(32'hFFFF_FFFF);
    check("R9 readback", reg_rdata, 32'h0001_FFFF);
    set_ctrl(32'h0);

    // Table of packing/order vectors: R2 R3 R4
    set_ctrl(cword(2'd0, 3'd6));
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  o;
      logic [2:0]  p;
      logic [23:0] px, ex;
      string       tg;
      {o, p, px, ex} = VEC[i];
      set_ctrl(cword(o, p));
      pix_in = px;
      step();
      tg = (o != 0) ? "R2 order" : ((p == 0 || p == 7) ? "R4 zero pack" : "R3 pack");
      check($sformatf("%s vec %0d", tg, i), {8'h0, pix_out}, {8'h0, ex});
      @(negedge clk);
    end

    // R11 one-cycle latency
    set_ctrl(cword(2'd0, 3'd6));
    pix_in = 24'h123456; step();
    @(negedge clk); pix_in = 24'hABCDEF; #1;
    check("R11 before edge", {8'h0, pix_out}, 32'h0012_3456);
    step();
    check("R11 after edge", {8'h0, pix_out}, 32'h00AB_CDEF);

    // R5 polarity
    set_ctrl(cword(2'd0, 3'd6) | (32'd1 << 9));
    hs_in = 1'b1; step();
    check("R5 hs inverted active", {31'h0, hs_out}, 32'h0);
    @(negedge clk); hs_in = 1'b0; step();
    check("R5 hs inverted idle", {31'h0, hs_out}, 32'h1);
    set_ctrl(cword(2'd0, 3'd6) | (32'd1 << 10));
    @(posedge clk); #1;
    check("R5 pclk inverted", {31'h0, pclk_out}, 32'h0);
    set_ctrl(cword(2'd0, 3'd6));
    @(posedge clk); #1;
    check("R5 pclk normal", {31'h0, pclk_out}, 32'h1);

    // R7 disable with inversion: stuck at inactive level
    set_ctrl(cword(2'd0, 3'd6) | (32'd1 << 9) | (32'd1 << 3));
    hs_in = 1'b1; step();
    check("R7 hs disabled", {31'h0, hs_out}, 32'h1);
    @(negedge clk);
    set_ctrl(cword(2'd0, 3'd6) | (32'd1 << 2));
    vs_in = 1'b1; step();
    check("R7 vs disabled", {31'h0, vs_out}, 32'h0);
    @(negedge clk); hs_in = 1'b0; vs_in = 1'b0;

    // R8 enable off: data zero, controls inactive after polarity
    set_ctrl((32'd1 << 16) | (32'd6 << 11) | (32'd1 << 8));
    pix_in = 24'hABCDEF; hs_in = 1'b1; vs_in = 1'b1; step();
    check("R8 off data", {8'h0, pix_out}, 32'h0);
    check("R8 off vs", {31'h0, vs_out}, 32'h1);
    check("R8 off hs", {31'h0, hs_out}, 32'h0);
    // R8 enable rising clears the stage
    @(negedge clk);
    vs_in = 1'b0;
    reg_wr = 1'b1; reg_addr = '0; reg_wdata = (32'd1 << 16) | (32'd6 << 11) | 32'd1;
    step();
    check("R8 cleared data", {8'h0, pix_out}, 32'h0);
    check("R8 cleared hs", {31'h0, hs_out}, 32'h0);
    @(negedge clk); reg_wr = 1'b0; step();
    check("R8 data after clear", {8'h0, pix_out}, 32'h00AB_CDEF);
    check("R8 hs after clear", {31'h0, hs_out}, 32'h1);
    @(negedge clk); hs_in = 1'b0;

    // R6 falling-edge launch of vsync
    set_ctrl(cword(2'd0, 3'd6) | (32'd1 << 5));
    step();
    @(negedge clk); vs_in = 1'b1; step();
    check("R6 vs first half", {31'h0, vs_out}, 32'h0);
    #2;
    check("R6 vs second half", {31'h0, vs_out}, 32'h1);
    @(negedge clk); vs_in = 1'b0;

    // R10 data-enable pin source
    set_ctrl(cword(2'd0, 3'd6));
    de_in = 1'b1; step();
    check("R10 de passthrough", {31'h0, de_out}, 32'h1);
    set_ctrl(cword(2'd0, 3'd6) & ~(32'd1 << 16));
    hs_in = 1'b1; vs_in = 1'b0; de_in = 1'b0; step();
    check("R10 csync hs only", {31'h0, de_out}, 32'h1);
    @(negedge clk); vs_in = 1'b1; de_in = 1'b1; step();
    check("R10 csync both", {31'h0, de_out}, 32'h0);
    @(negedge clk); hs_in = 1'b0; vs_in = 1'b0; step();
    check("R10 csync none", {31'h0, de_out}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule